// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Misuse Pulses

This block carries a stream of data words from a fast receive clock domain to an unrelated, usually much slower, consumer clock domain. On the write side a character arrives each cycle that `wrValid` is high. A character equal to the configured idle code is discarded at the input, and every other character is queued. The read side pops one word per `rdPop` strobe. The popped word is registered, so it appears on `rdData` with `rdValid` high in the read-clock cycle after the strobe.

The write and read pointers each carry an extra wrap bit. They cross between the domains as Gray code through two-flop synchronizers. Full is computed in the write domain and empty in the read domain, each from the synchronized pointer of the other side, so both flags are pessimistic. Misuse does no harm. A push into a full FIFO is dropped, and a pop from an empty FIFO is ignored. Each raises a one-cycle error pulse in its own domain, and neither touches the pointers or the stored words.

Top module: `xdom_fifo`

## Requirements
- R1: While both resets are held, and after they are released, `wrFull`=0, `wrErr`=0, `rdEmpty`=1, `rdErr`=0 and `rdValid`=0.
- R2: A character equal to `IDLE_CODE` (default 16'h03C5) offered with `wrValid`=1 is never stored. It never clears `rdEmpty` and never appears on `rdData`.
- R3: Every stored word is delivered exactly once, in write order, with no duplicates, skips or replays, under both concurrent and bursty traffic.
- R4: A pop accepted while `rdEmpty`=0 gives `rdValid`=1 and the next stored word on `rdData` in the following read-clock cycle.
- R5: With no reads, `wrFull` is 0 after DEPTH-1 stored words and becomes 1 after the DEPTH-th stored word (default DEPTH is 16).
- R6: A non-idle push while `wrFull`=1 is dropped and leaves the write pointer and memory unchanged. `wrErr` is high for exactly the following write-clock cycle.
- R7: A pop while `rdEmpty`=1 leaves the read pointer unchanged and keeps `rdValid` at 0. `rdErr` is high for exactly the following read-clock cycle, and later traffic is unaffected.
- R8: An idle character offered while `wrFull`=1 raises no `wrErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| wrRst | input | 1 | Write-domain synchronous reset, active high |
| wrValid | input | 1 | A character is present on `wrChar` |
| wrChar | input | DW | Incoming character |
| wrFull | output | 1 | No room for another word (pessimistic) |
| wrErr | output | 1 | One-cycle pulse: a push was dropped because the FIFO was full |
| rdClk | input | 1 | Read-domain clock |
| rdRst | input | 1 | Read-domain synchronous reset, active high |
| rdPop | input | 1 | Pop request |
| rdData | output | DW | Word popped in the previous read cycle |
| rdValid | output | 1 | `rdData` holds a freshly popped word |
| rdEmpty | output | 1 | Nothing to pop (pessimistic) |
| rdErr | output | 1 | One-cycle pulse: a pop was ignored because the FIFO was empty |

## Verification
The assertions assume that both resets are applied together before any traffic, and that each reset lasts long enough to flush the synchronizer chains. The stimulus holds both resets over several cycles of each clock and releases them before the first strobe. The assertions do not assume the strobes respect the flags. The stimulus therefore drives pushes into a full FIFO and pops from an empty one on purpose. It runs the two clocks at a non-integer ratio, so the pointers are synchronized at shifting phases.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;
  // Strobes from the pointer control to the storage datapath.
  typedef struct packed {
    logic wrStb;  // write-clock domain: store wrChar at the write address
    logic rdStb;  // read-clock domain: register the word at the read address
  } memStrobe_t;
endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= dIn;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/xdom_fifo_ctl.sv
module xdom_fifo_ctl
  import xdom_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          wrRst,
  input  logic          wrPush,
  output logic          wrFull,
  output logic          wrErr,
  output logic [AW-1:0] wrAddr,
  input  logic          rdClk,
  input  logic          rdRst,
  input  logic          rdPop,
  output logic          rdEmpty,
  output logic          rdErr,
  output logic [AW-1:0] rdAddr,
  output memStrobe_t    stb
);
  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] rdGrayAtWr, wrGrayAtRd;
  logic [PW-1:0] rdBinAtWr, wrBinAtRd;

  xdom_sync #(.W(PW), .STAGES(2)) i_rdToWr (
    .clk(wrClk), .rst(wrRst), .dIn(rdGray), .dOut(rdGrayAtWr));
  xdom_sync #(.W(PW), .STAGES(2)) i_wrToRd (
    .clk(rdClk), .rst(rdRst), .dIn(wrGray), .dOut(wrGrayAtRd));

  assign rdBinAtWr = gray2bin(rdGrayAtWr);
  assign wrBinAtRd = gray2bin(wrGrayAtRd);

  // ---------------- write domain ----------------
  assign wrFull    = (wrBin[AW] != rdBinAtWr[AW]) && (wrBin[AW-1:0] == rdBinAtWr[AW-1:0]);
  assign stb.wrStb = wrPush && !wrFull;
  assign wrBinNext = wrBin + PW'(1);
  assign wrAddr    = wrBin[AW-1:0];

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      wrBin  <= '0;
      wrGray <= '0;
      wrErr  <= 1'b0;
    end else begin
      wrErr <= wrPush && wrFull;
      if (stb.wrStb) begin
        wrBin  <= wrBinNext;
        wrGray <= bin2gray(wrBinNext);
      end
    end
  end

  // ---------------- read domain ----------------
  assign rdEmpty   = (rdBin == wrBinAtRd);
  assign stb.rdStb = rdPop && !rdEmpty;
  assign rdBinNext = rdBin + PW'(1);
  assign rdAddr    = rdBin[AW-1:0];

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdBin  <= '0;
      rdGray <= '0;
      rdErr  <= 1'b0;
    end else begin
      rdErr <= rdPop && rdEmpty;
      if (stb.rdStb) begin
        rdBin  <= rdBinNext;
        rdGray <= bin2gray(rdBinNext);
      end
    end
  end

  // ---------------- assertions ----------------
  // R6
  wr_full_block_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrPush && wrFull) |=> (wrErr && $stable(wrBin)));
  // R5
  wr_occupancy_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    PW'(wrBin - rdBinAtWr) <= PW'(DEPTH));
  // R3
  wr_gray_step_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  // R7
  rd_empty_block_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdPop && rdEmpty) |=> (rdErr && $stable(rdBin)));
  // R3
  rd_occupancy_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    PW'(wrBinAtRd - rdBin) <= PW'(DEPTH));
  // R3
  rd_gray_step_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    $countones(rdGray ^ $past(rdGray)) <= 1);
endmodule

// File: rtl/xdom_fifo_mem.sv
module xdom_fifo_mem
  import xdom_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdClk,
  input  logic          rdRst,
  input  logic [AW-1:0] rdAddr,
  input  memStrobe_t    stb,
  output logic [DW-1:0] rdData,
  output logic          rdValid
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdStb;
      if (stb.rdStb) rdData <= store[rdAddr];
    end
  end
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo
  import xdom_fifo_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          DEPTH     = 16,
  parameter logic [15:0] IDLE_CODE = 16'h03C5,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          wrRst,
  input  logic          wrValid,
  input  logic [DW-1:0] wrChar,
  output logic          wrFull,
  output logic          wrErr,
  input  logic          rdClk,
  input  logic          rdRst,
  input  logic          rdPop,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          rdEmpty,
  output logic          rdErr
);
  logic          wrPush;
  logic [AW-1:0] wrAddr, rdAddr;
  memStrobe_t    stb;

  // Idle characters are dropped before they can request storage.
  assign wrPush = wrValid && (wrChar != DW'(IDLE_CODE));

  xdom_fifo_ctl #(.DEPTH(DEPTH)) i_ctl (
    .wrClk(wrClk), .wrRst(wrRst), .wrPush(wrPush), .wrFull(wrFull),
    .wrErr(wrErr), .wrAddr(wrAddr),
    .rdClk(rdClk), .rdRst(rdRst), .rdPop(rdPop), .rdEmpty(rdEmpty),
    .rdErr(rdErr), .rdAddr(rdAddr), .stb(stb));

  xdom_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) i_mem (
    .wrClk(wrClk), .wrAddr(wrAddr), .wrData(wrChar),
    .rdClk(rdClk), .rdRst(rdRst), .rdAddr(rdAddr), .stb(stb),
    .rdData(rdData), .rdValid(rdValid));

  // R7
  rd_err_no_data_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    !(rdErr && rdValid));
endmodule

// File: tb/test_xdom_fifo.sv
`timescale 1ns/1ps
module test_xdom_fifo;
  localparam int WPERIOD = 10;
  localparam int RPERIOD = 26;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam logic [DW-1:0] IDLE = 16'h03C5;

  logic wrClk = 0, rdClk = 0, wrRst = 1, rdRst = 1;
  logic wrValid = 0, rdPop = 0;
  logic [DW-1:0] wrChar = '0;
  logic wrFull, wrErr, rdValid, rdEmpty, rdErr;
  logic [DW-1:0] rdData;

  int checks = 0, fails = 0, stored = 0, delivered = 0;
  logic [DW-1:0] expQ [$];

  always #(WPERIOD/2) wrClk = ~wrClk;
  always #(RPERIOD/2) rdClk = ~rdClk;

  xdom_fifo #(.DW(DW), .DEPTH(DEPTH), .IDLE_CODE(IDLE)) i_xdom_fifo (
    .wrClk(wrClk), .wrRst(wrRst), .wrValid(wrValid), .wrChar(wrChar),
    .wrFull(wrFull), .wrErr(wrErr),
    .rdClk(rdClk), .rdRst(rdRst), .rdPop(rdPop), .rdData(rdData),
    .rdValid(rdValid), .rdEmpty(rdEmpty), .rdErr(rdErr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: call aligned to a write negedge; returns aligned to the next one.
  task automatic wrAttempt(input logic [DW-1:0] ch);
    bit wasFull;
    wasFull = wrFull;
    wrValid = 1; wrChar = ch;
    if (ch != IDLE && !wasFull) begin expQ.push_back(ch); stored++; end
    @(negedge wrClk);
    wrValid = 0;
    if (ch == IDLE) chk("R8 idle gives no wrErr", wrErr, 0);
    else            chk("R6 wrErr pulse on full push", wrErr, wasFull);
  endtask

  // Reader: call aligned to a read negedge; returns aligned to the next one.
  task automatic rdAttempt();
    bit wasEmpty;
    wasEmpty = rdEmpty;
    rdPop = 1;
    @(negedge rdClk);
    rdPop = 0;
    chk("R7 rdErr on empty pop", rdErr, wasEmpty);
    chk("R4 rdValid cycle after pop", rdValid, !wasEmpty);
  endtask

  // Monitor: compares every delivered word against the scoreboard queue (R3).
  initial begin
    forever begin
      @(negedge rdClk);
      if (rdValid) begin
        delivered++;
        if (expQ.size() == 0) chk("R3 unexpected word", rdData, 32'hFFFF_FFFF);
        else chk("R3 word order", rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    #(WPERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge rdClk);
    // R1 during reset
    chk("R1 rdEmpty in reset", rdEmpty, 1);
    chk("R1 wrFull in reset", wrFull, 0);
    wrRst = 0; rdRst = 0;
    @(negedge rdClk);
    chk("R1 rdEmpty", rdEmpty, 1);
    chk("R1 rdValid", rdValid, 0);
    chk("R1 rdErr", rdErr, 0);
    @(negedge wrClk);
    chk("R1 wrFull", wrFull, 0);
    chk("R1 wrErr", wrErr, 0);

    // R2: idles only must not make anything visible
    repeat (3) wrAttempt(IDLE);
    repeat (6) @(negedge rdClk);
    chk("R2 idle not stored", rdEmpty, 1);

    // R5: fill with idles mixed in
    @(negedge wrClk);
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 4 == 1) wrAttempt(IDLE);
      wrAttempt(DW'(16'h1000 + i));
      if (i == DEPTH - 2) chk("R5 not full at DEPTH-1", wrFull, 0);
    end
    chk("R5 full at DEPTH", wrFull, 1);
    // R6 overflow pushes and R8 idle while full
    wrAttempt(16'hDEAD);
    chk("R6 wrErr single pulse", wrErr, 1);
    @(negedge wrClk);
    chk("R6 wrErr cleared", wrErr, 0);
    wrAttempt(16'hBEEF);
    wrAttempt(IDLE);
    chk("R6 still full", wrFull, 1);

    // Drain: contents must be the DEPTH words, overflow words absent
    @(negedge rdClk);
    for (int i = 0; i < DEPTH; i++) rdAttempt();
    chk("R3 drained", expQ.size(), 0);
    chk("R7 empty after drain", rdEmpty, 1);
    rdAttempt();
    @(negedge rdClk);
    chk("R7 rdErr one cycle", rdErr, 0);
    chk("R7 no data on bad pop", rdValid, 0);

    // Concurrent traffic with misuse on both sides
    fork
      begin
        @(negedge wrClk);
        for (int i = 0; i < 300; i++) begin
          logic [DW-1:0] ch;
          ch = ($urandom_range(0, 4) == 0) ? IDLE : DW'($urandom);
          wrAttempt(ch);
          if ($urandom_range(0, 7) == 0) repeat ($urandom_range(1, 30)) @(negedge wrClk);
        end
      end
      begin
        @(negedge rdClk);
        for (int i = 0; i < 250; i++) begin
          rdAttempt();
          if ($urandom_range(0, 5) == 0) repeat ($urandom_range(1, 12)) @(negedge rdClk);
        end
      end
    join

    // Final drain
    @(negedge rdClk);
    for (int i = 0; i < 400; i++) begin
      if (expQ.size() == 0 && rdEmpty) break;
      rdAttempt();
    end
    repeat (4) @(negedge rdClk);
    chk("R3 all words delivered once", delivered, stored);
    chk("R3 queue empty", expQ.size(), 0);
    rdAttempt();
    chk("R7 normal after misuse", rdEmpty, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule